// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block collects the event pulses of an I2C controller's bus engine into sticky pending flags. An enable mask selects which of them may interrupt. The block drives one interrupt line while any enabled flag is pending. It also offers a vector register that names the most urgent enabled flag with a fixed 3-bit code.

An interrupt handler reads the vector, services the source it names, and reads again until the vector returns zero. Each vector read acknowledges the source it reports, so successive reads walk down the pending list in priority order. Software can also clear the access-ready and stop-detected flags directly through the status register. Two live levels, bus busy and receive shift register full, are mirrored in the status register for software to poll. They never interrupt.

All registers sit behind a small read/write port. The register select field chooses the mask, status or vector register. Read data is combinational from the current state, and every side effect of an access takes place at the next rising clock edge.

Top module: `i2c_irq_vector_enc`

## Requirements
- R1: After a synchronous active-low reset, the mask register, all pending flags, the vector register and `irq_o` read zero.
- R2: A pulse on `evt_i[i]` sets pending flag i at the next rising edge. The flag then stays set until it is cleared. The pending flags read back in status register bits 6:0.
- R3: The event input bits, the status bits and the mask bits all use the same positions: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. The vector register (select 2) returns code i+1 in bits 2:0 for the source at bit i, and reads 0 when no enabled flag is pending.
- R4: When several enabled flags are pending, the vector reports the lowest code, so arbitration lost has the highest priority.
- R5: A source whose mask bit is 0 never appears in the vector and does not drive `irq_o`. Any single mask bit, such as receive ready or transmit ready, can be turned off while the others stay on.
- R6: `irq_o` is high exactly when at least one pending flag has its mask bit set.
- R7: A read of the vector register clears, at the next edge, the flag whose code it returned. A read that returns 0 clears nothing.
- R8: Writing the status register (select 1) with a 1 in bit 2 or bit 5 clears that flag. A 0 in those bits leaves the flag unchanged, and writes to every other status bit have no effect.
- R9: Status bit 11 mirrors `rx_shift_full_i` and bit 12 mirrors `bus_busy_i` in the same cycle. Neither of these levels affects `irq_o` or the vector.
- R10: If an event pulse and a clear of the same flag (a vector read or a status write) fall in the same cycle, the flag stays set.
- R11: The mask register (select 0) stores write-data bits 6:0 and reads them back with all upper bits zero. Select 3 reads zero.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | Single-cycle event pulses, one bit per source |
| bus_busy_i | input | 1 | Live bus-busy level |
| rx_shift_full_i | input | 1 | Live receive-shift-full level |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 none |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effects on vector reads) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
Two actions can fall in the same cycle on the same flag: a fresh event pulse that sets it, and an acknowledge that clears it. The acknowledge may be a vector read or a write-one-to-clear of the status register. Directed cases pulse a source in the very cycle its vector read or status clear is issued. The random phase produces many more such overlaps, because it pulses events while reading the vector and writing the status register. A bench model applies the rule that the event wins and predicts the following status and vector reads, which are compared with the hardware.

// File: rtl/i2civ_pkg.sv
// Package: shared register select encoding and fixed bit positions for the
// I2C interrupt vector encoder. Assumes a 2-bit register select.
package i2civ_pkg;

    // Register select values on the access port
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_NONE = 2'd3
    } regsel_e;

    // Source positions (shared by events, mask and status)
    localparam int SRC_ARB_LOST = 0;
    localparam int SRC_NO_ACK   = 1;
    localparam int SRC_ACC_RDY  = 2;
    localparam int SRC_RX_RDY   = 3;
    localparam int SRC_TX_RDY   = 4;
    localparam int SRC_STOP_DET = 5;
    localparam int SRC_AS_SLAVE = 6;

endpackage

// File: rtl/i2civ_flag_cell.sv
// Module: one sticky pending flag. A set pulse latches it; a clear drops it.
// Assumes set and clear are single-cycle strobes; set has priority over clear.
module i2civ_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Purpose: hold the flag; the event beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/i2civ_prio_enc.sv
// Module: fixed-priority encoder. Returns index+1 of the lowest set request
// bit, or 0 when none is set, plus a one-hot of the winner.
// Assumes NUM_REQ+1 fits in CODE_W bits.
module i2civ_prio_enc #(
    parameter int NUM_REQ = 7,
    parameter int CODE_W  = $clog2(NUM_REQ + 1)
) (
    input  logic [NUM_REQ-1:0] req_i,
    output logic [CODE_W-1:0]  code_o,
    output logic [NUM_REQ-1:0] win_o
);

    // Purpose: scan from the highest index down so the lowest index wins.
    always_comb begin
        code_o = '0;
        win_o  = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o = CODE_W'(i + 1);
                win_o  = '0;
                win_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2civ_reg_port.sv
// Module: register access port. Holds the enable mask, decodes status
// write-one-to-clear and vector acknowledge, and muxes read data.
// Assumes reads are combinational; all side effects land at the next edge.
module i2civ_reg_port
    import i2civ_pkg::*;
#(
    parameter int              NUM_SRC = 7,
    parameter int              DATA_W  = 16,
    parameter int              CODE_W  = 3,
    parameter int              RSF_BIT = 11,
    parameter int              BB_BIT  = 12,
    parameter logic [NUM_SRC-1:0] W1C_BITS = 7'b010_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_sel_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [CODE_W-1:0]  vec_code_i,
    input  logic [NUM_SRC-1:0] vec_win_i,
    input  logic               bus_busy_i,
    input  logic               rx_shift_full_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] clr_o
);

    regsel_e              sel;
    logic [NUM_SRC-1:0]   mask_q;
    logic [NUM_SRC-1:0]   w1c_clr;
    logic [NUM_SRC-1:0]   ack_clr;

    assign sel = regsel_e'(reg_sel_i);

    // Purpose: store the enable mask on a write to the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_wr_i && sel == SEL_MASK) begin
            mask_q <= reg_wdata_i[NUM_SRC-1:0];
        end
    end

    // Purpose: write-one-to-clear, limited to the clearable status bits.
    always_comb begin
        w1c_clr = '0;
        if (reg_wr_i && sel == SEL_STAT) begin
            w1c_clr = reg_wdata_i[NUM_SRC-1:0] & W1C_BITS;
        end
    end

    // Purpose: a vector read acknowledges the source it reports.
    always_comb begin
        ack_clr = '0;
        if (reg_rd_i && sel == SEL_VEC && vec_code_i != '0) begin
            ack_clr = vec_win_i;
        end
    end

    // Purpose: read data mux for the selected register.
    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_MASK: reg_rdata_o[NUM_SRC-1:0] = mask_q;
            SEL_STAT: begin
                reg_rdata_o[NUM_SRC-1:0] = pend_i;
                reg_rdata_o[RSF_BIT]     = rx_shift_full_i;
                reg_rdata_o[BB_BIT]      = bus_busy_i;
            end
            SEL_VEC:  reg_rdata_o[CODE_W-1:0] = vec_code_i;
            SEL_NONE: reg_rdata_o = '0;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;
    assign clr_o  = w1c_clr | ack_clr;

endmodule

// File: rtl/i2c_irq_vector_enc.sv
// Module: I2C interrupt vector encoder top. Latches event pulses into sticky
// flags, masks them, drives one interrupt line and an encoded vector.
// Assumes events are single-cycle pulses synchronous to clk.
module i2c_irq_vector_enc #(
    parameter int NUM_SRC = 7,
    parameter int DATA_W  = 16,
    parameter int RSF_BIT = 11,
    parameter int BB_BIT  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic              bus_busy_i,
    input  logic              rx_shift_full_i,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int CODE_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] live_req;
    logic [NUM_SRC-1:0] vec_win;
    logic [CODE_W-1:0]  vec_code;

    // One sticky flag per source
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_flag
            i2civ_flag_cell u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt_i[g]),
                .clr_i  (clr[g]),
                .flag_o (pend_q[g])
            );
        end
    endgenerate

    assign live_req = pend_q & mask_q;

    i2civ_prio_enc #(
        .NUM_REQ (NUM_SRC),
        .CODE_W  (CODE_W)
    ) u_enc (
        .req_i  (live_req),
        .code_o (vec_code),
        .win_o  (vec_win)
    );

    i2civ_reg_port #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .CODE_W  (CODE_W),
        .RSF_BIT (RSF_BIT),
        .BB_BIT  (BB_BIT)
    ) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_sel_i       (reg_sel_i),
        .reg_wr_i        (reg_wr_i),
        .reg_rd_i        (reg_rd_i),
        .reg_wdata_i     (reg_wdata_i),
        .reg_rdata_o     (reg_rdata_o),
        .pend_i          (pend_q),
        .vec_code_i      (vec_code),
        .vec_win_i       (vec_win),
        .bus_busy_i      (bus_busy_i),
        .rx_shift_full_i (rx_shift_full_i),
        .mask_o          (mask_q),
        .clr_o           (clr)
    );

    // Interrupt line: any enabled pending flag
    assign irq_o = |live_req;

endmodule

// File: rtl/i2civ_checker.sv
// Module: property checker for the interrupt vector encoder, bound to the top.
module i2civ_checker #(
    parameter int NUM_SRC = 7,
    parameter int CODE_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [1:0]         reg_sel_i,
    input logic               reg_rd_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [CODE_W-1:0]  vec_code
);

    // R2 R10
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // R5
    masked_never_vectored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> mask_q[vec_code - CODE_W'(1)]);

    // R4
    lowest_code_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |->
        (((pend_q & mask_q) & ((NUM_SRC'(1) << (vec_code - CODE_W'(1))) - NUM_SRC'(1))) == '0));

    // R6
    irq_matches_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_code != '0));

    // R7
    ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_sel_i == 2'd2 && vec_code != '0 &&
         !evt_i[vec_code - CODE_W'(1)])
        |=> !pend_q[$past(vec_code) - CODE_W'(1)]);

endmodule

bind i2c_irq_vector_enc i2civ_checker #(
    .NUM_SRC (NUM_SRC),
    .CODE_W  (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .reg_sel_i (reg_sel_i),
    .reg_rd_i  (reg_rd_i),
    .irq_o     (irq_o),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .vec_code  (vec_code)
);

// File: tb/tb_i2c_irq_vector_enc.sv
module tb_i2c_irq_vector_enc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_i = '0;
    logic        bus_busy_i = 1'b0;
    logic        rx_shift_full_i = 1'b0;
    logic [1:0]  reg_sel_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    logic [6:0] m_pend = '0;
    logic [6:0] m_mask = '0;

    always #10 clk = ~clk;

    i2c_irq_vector_enc dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
        .rx_shift_full_i(rx_shift_full_i), .reg_sel_i(reg_sel_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    function automatic logic [2:0] exp_code(input logic [6:0] p, input logic [6:0] m);
        for (int i = 6; i >= 0; i--) if (p[i] && m[i]) exp_code = 3'(i + 1);
        if ((p & m) == 7'd0) exp_code = 3'd0;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [1:0] s);
        logic [15:0] r;
        r = '0;
        case (s)
            2'd0: r[6:0] = m_mask;
            2'd1: begin r[6:0] = m_pend; r[11] = rx_shift_full_i; r[12] = bus_busy_i; end
            2'd2: r[2:0] = exp_code(m_pend, m_mask);
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input logic [6:0] ev, input logic [1:0] sel, input logic wr,
                        input logic rd, input logic [15:0] wd, input logic bb, input logic rsf);
        string tg;
        logic [6:0] clr;
        logic [2:0] c;
        @(negedge clk);
        evt_i = ev; reg_sel_i = sel; reg_wr_i = wr; reg_rd_i = rd;
        reg_wdata_i = wd; bus_busy_i = bb; rx_shift_full_i = rsf;
        #1;
        case (sel)
            2'd0: tg = "R11 mask readback";
            2'd1: tg = "R2/R9 status readback";
            2'd2: tg = "R3/R4/R5 vector readback";
            default: tg = "R11 unused select";
        endcase
        check(tg, reg_rdata_o, exp_rdata(sel));
        check("R6 irq level", {15'd0, irq_o}, {15'd0, ((m_pend & m_mask) != 7'd0)});
        @(posedge clk);
        c = exp_code(m_pend, m_mask);
        clr = '0;
        if (wr && sel == 2'd1) clr = wd[6:0] & 7'b010_0100;
        if (rd && sel == 2'd2 && c != 3'd0) clr[c - 3'd1] = 1'b1;
        if (wr && sel == 2'd0) m_mask = wd[6:0];
        m_pend = (m_pend & ~clr) | ev;
    endtask

    task automatic idle_read(input logic [1:0] sel, input logic rd);
        step(7'd0, sel, 1'b0, rd, 16'd0, bus_busy_i, rx_shift_full_i);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // R1: reset state of every register and the line
        @(negedge clk); rst_n = 1'b1;
        reg_sel_i = 2'd0; #1; check("R1 mask after reset", reg_rdata_o, 16'd0);
        reg_sel_i = 2'd1; #1; check("R1 status after reset", reg_rdata_o, 16'd0);
        reg_sel_i = 2'd2; #1; check("R1 vector after reset", reg_rdata_o, 16'd0);
        check("R1 irq after reset", {15'd0, irq_o}, 16'd0);

        // R11: enable all; upper write bits dropped
        step(7'd0, 2'd0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);
        idle_read(2'd0, 1'b0);
        // R3 R4 R7: all pending, walk the vector down to zero
        step(7'h7F, 2'd3, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk); reg_sel_i = 2'd2; evt_i = '0; reg_rd_i = 1'b0; reg_wr_i = 1'b0; #1;
            check("R3 R4 R7 vector walk", reg_rdata_o, (k <= 7) ? 16'(k) : 16'd0);
            step(7'd0, 2'd2, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0);
        end

        // R5: disable receive-ready and transmit-ready, pulse them plus stop
        step(7'd0, 2'd0, 1'b1, 1'b0, 16'h0067, 1'b0, 1'b0);
        step(7'b011_1000, 2'd3, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0);
        @(negedge clk); reg_sel_i = 2'd2; #1;
        check("R5 masked rx/tx skipped", reg_rdata_o, 16'd6);
        idle_read(2'd2, 1'b1);
        @(negedge clk); reg_sel_i = 2'd2; #1;
        check("R5 masked sources give no vector", reg_rdata_o, 16'd0);
        check("R5 masked sources give no irq", {15'd0, irq_o}, 16'd0);
        @(negedge clk); reg_sel_i = 2'd1; #1;
        check("R5 masked flags still pending", reg_rdata_o, 16'h0018);

        // R8: W1C on bit 0 ignored, bits 2 and 5 cleared
        step(7'b010_0101, 2'd3, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0);
        step(7'd0, 2'd1, 1'b1, 1'b0, 16'h007F, 1'b0, 1'b0);
        @(negedge clk); reg_sel_i = 2'd1; reg_wr_i = 1'b0; #1;
        check("R8 only bits 2 and 5 cleared", reg_rdata_o, 16'h0019);
        step(7'd0, 2'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0);
        @(negedge clk); reg_sel_i = 2'd1; reg_wr_i = 1'b0; #1;
        check("R8 zero write leaves flags", reg_rdata_o, 16'h0019);

        // R10: event and W1C collide on bit 2; event and vector ack on bit 0
        step(7'b000_0100, 2'd3, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0);
        step(7'b000_0100, 2'd1, 1'b1, 1'b0, 16'h0004, 1'b0, 1'b0);
        @(negedge clk); reg_sel_i = 2'd1; reg_wr_i = 1'b0; #1;
        check("R10 event beats status clear", reg_rdata_o & 16'h0004, 16'h0004);
        step(7'b000_0001, 2'd2, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0);
        @(negedge clk); reg_sel_i = 2'd2; reg_rd_i = 1'b0; #1;
        check("R10 event beats vector ack", reg_rdata_o, 16'd1);

        // R9: live levels visible, irq unaffected
        step(7'd0, 2'd1, 1'b1, 1'b0, 16'h0004, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) idle_read(2'd2, 1'b1);
        @(negedge clk); reg_sel_i = 2'd1; bus_busy_i = 1'b1; rx_shift_full_i = 1'b1; #1;
        check("R9 live bits mirror inputs", reg_rdata_o & 16'h1800, 16'h1800);
        check("R9 live bits raise no irq", {15'd0, irq_o}, {15'd0, ((m_pend & m_mask) != 7'd0)});

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [6:0] ev;
            logic [1:0] s;
            logic [15:0] wd;
            ev = 7'($urandom & $urandom & $urandom);
            s  = 2'($urandom);
            wd = 16'($urandom);
            step(ev, s, ($urandom % 4) == 0, ($urandom % 2) == 0, wd,
                 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule